// File: doc/BRIEF.md
# Phase/Frequency Detector Control with Lock Sense and Power-Down Sequencing

This block is the digital core of a two-channel phase/frequency detector. Each channel watches single-cycle edge strobes from its reference divider and its feedback divider. It keeps a pair of pump-request flip-flops that are set by those strobes and cleared together a short, parameterised time after both are set. The pump requests then pass through a per-channel polarity swap, a tristate gate and a registered 1x/4x magnitude select. A downstream analog charge pump, which is not part of this block, consumes them.

Each channel reports an active-high lock flag and can be powered down in one of two ways. In immediate mode the channel shuts down at the next clock edge. In gated mode it first lets the pump pulse in flight finish. A powered-down channel holds its divider counters in reset and releases its pump. A shared reference-input buffer enable stays active until both channels are down. One multiplexed test output, steered by a four-bit code, carries one of the following: a lock flag, a divider strobe, the fast-lock resistor switch, or a counter-reset mode that forces channels off.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: A reference strobe sets a channel's up request and a feedback strobe sets its down request, each on the next clock edge. With RST_DLY = 1, once both requests are set they both clear on the following edge. Coincident strobes therefore give equal one-cycle up and down pulses.
- R2: With the channel's polarity bit at 1, pump_up follows the up request and pump_dn follows the down request. With the bit at 0, the two are swapped.
- R3: The applied magnitude pump_4x takes the configured 4x bit only on an edge where neither pump request of that channel is set. Otherwise it holds its value.
- R4: With the channel's tristate bit at 1, asserting power-down makes pdn_state high on the next clock edge, even while a pump pulse is active.
- R5: With the tristate bit at 0, asserting power-down leaves pdn_state low while a pump request is set. It goes high on the first edge at which no request is set.
- R6: While pdn_state is high: pump_up, pump_dn and pump_oe are 0, ctr_rst is 1, and strobes set no request. Deasserting power-down clears pdn_state on the next edge.
- R7: lock is high when no pump request is set or the channel is powered down, and low during an active pump request.
- R8: mux_sel[3:0] = 0000 drives mux_out low. 0100 gives lock of channel 1, 1000 gives lock of channel 0, and 1100 gives the AND of both locks.
- R9: mux_sel ?001 outputs ref_edge[1], ?010 outputs ref_edge[0], ?101 outputs fb_edge[1], and ?110 outputs fb_edge[0].
- R10: mux_sel 0011 drives mux_out with channel 0's applied pump_4x, which is the fast-lock switch. The switch is never active in any other code.
- R11: mux_sel 0111 forces ctr_rst[1] high and pump_oe[1] low. 1011 does the same for channel 0, and 1111 does it for both. In these modes mux_out is low and the affected channel's requests clear on the next edge.
- R12: osc_buf_en is low exactly when both channels are powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_edge | input | 2 | Reference-divider strobe per channel |
| fb_edge | input | 2 | Feedback-divider strobe per channel |
| cfg_pol | input | 2 | Polarity bit per channel (1 = no swap) |
| cfg_hiz | input | 2 | Tristate bit per channel (1 = immediate power-down) |
| cfg_4x | input | 2 | Requested 4x magnitude per channel |
| cfg_pwdn | input | 2 | Power-down request per channel |
| mux_sel | input | 4 | Test-output / reset mode code |
| pump_up | output | 2 | Up command to charge pump |
| pump_dn | output | 2 | Down command to charge pump |
| pump_oe | output | 2 | Pump drive enable (0 = tristate) |
| pump_4x | output | 2 | Applied magnitude select |
| lock | output | 2 | Lock flag per channel |
| pdn_state | output | 2 | Channel is powered down |
| ctr_rst | output | 2 | Hold reference and feedback counters in reset |
| osc_buf_en | output | 1 | Shared reference-input buffer enable |
| mux_out | output | 1 | Multiplexed test / fast-lock output |

## Verification
The detector is driven with four strobe patterns:
- A reference edge leading a feedback edge, and the reverse. These show which flip-flop owns each edge and where the pulse ends.
- Strictly coincident edges. These expose the reset-delay pulse, which a dead-zone design would drop.
- The same patterns with the polarity bit cleared, to show the swap.

Power-down is requested while a pulse is in flight, under both tristate settings. This separates the gated shutdown from the immediate one, and a third run brings both channels down to reach the buffer-enable case. All sixteen multiplexer codes are swept with strobes and magnitude changes present. This separates lock, divider, fast-lock and reset selections, and a behavioural model is compared on every clock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int NCH  = 2;
  localparam int SELW = 4;
  localparam logic [SELW-1:0] SEL_RST_B   = 4'b0111;
  localparam logic [SELW-1:0] SEL_RST_A   = 4'b1011;
  localparam logic [SELW-1:0] SEL_RST_ALL = 4'b1111;
  localparam logic [SELW-1:0] SEL_FAST    = 4'b0011;
endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int RST_DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic ref_edge,
  input  logic fb_edge,
  output logic up_q,
  output logic dn_q
);
  localparam int CW = (RST_DLY < 2) ? 1 : $clog2(RST_DLY);
  localparam logic [CW-1:0] CNT_LAST = CW'(RST_DLY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_d, dn_d, both, clr;

  always_comb begin
    both  = up_q & dn_q;
    clr   = both && (cnt_q == CNT_LAST);
    cnt_d = (both && !clr && !hold) ? cnt_q + CW'(1) : '0;
    if (hold) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      up_d = (up_q & ~clr) | ref_edge;
      dn_d = (dn_q & ~clr) | fb_edge;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      up_q  <= up_d;
      dn_q  <= dn_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pfd_chan_ctrl.sv
module pfd_chan_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn,
  input  logic cfg_hiz,
  input  logic cfg_4x,
  input  logic pol,
  input  logic mux_rst,
  input  logic up_q,
  input  logic dn_q,
  output logic hold,
  output logic pd_q,
  output logic mag_q,
  output logic up_o,
  output logic dn_o,
  output logic oe,
  output logic lock
);
  logic active, pd_d, mag_en;

  always_comb begin
    active = up_q | dn_q;
    // gated entry waits for the pulse; tristate mode enters at once
    pd_d   = pwdn & (pd_q | cfg_hiz | ~active);
    mag_en = ~active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= 1'b0;
      mag_q <= 1'b0;
    end else begin
      pd_q <= pd_d;
      if (mag_en) mag_q <= cfg_4x;
    end
  end

  always_comb begin
    hold = pd_q | mux_rst;
    oe   = ~hold;
    up_o = oe & (pol ? up_q : dn_q);
    dn_o = oe & (pol ? dn_q : up_q);
    lock = pd_q | ~active;
  end
endmodule

// File: rtl/pfd_out_mux.sv
module pfd_out_mux
  import pfd_pkg::*;
(
  input  logic [SELW-1:0] sel,
  input  logic [NCH-1:0]  lock,
  input  logic [NCH-1:0]  ref_edge,
  input  logic [NCH-1:0]  fb_edge,
  input  logic            fast_mag,
  output logic            mux_out,
  output logic [NCH-1:0]  mux_rst
);
  always_comb begin
    mux_out = 1'b0;
    mux_rst = '0;
    casez (sel)
      4'b0000: mux_out = 1'b0;
      4'b0100: mux_out = lock[1];
      4'b1000: mux_out = lock[0];
      4'b1100: mux_out = lock[0] & lock[1];
      4'b?001: mux_out = ref_edge[1];
      4'b?010: mux_out = ref_edge[0];
      4'b?101: mux_out = fb_edge[1];
      4'b?110: mux_out = fb_edge[0];
      SEL_FAST:    mux_out = fast_mag;
      SEL_RST_B:   mux_rst[1] = 1'b1;
      SEL_RST_A:   mux_rst[0] = 1'b1;
      SEL_RST_ALL: mux_rst = '1;
      default:     mux_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
  import pfd_pkg::*;
#(
  parameter int RST_DLY     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ref_edge,
  input  logic [NCH-1:0]  fb_edge,
  input  logic [NCH-1:0]  cfg_pol,
  input  logic [NCH-1:0]  cfg_hiz,
  input  logic [NCH-1:0]  cfg_4x,
  input  logic [NCH-1:0]  cfg_pwdn,
  input  logic [SELW-1:0] mux_sel,
  output logic [NCH-1:0]  pump_up,
  output logic [NCH-1:0]  pump_dn,
  output logic [NCH-1:0]  pump_oe,
  output logic [NCH-1:0]  pump_4x,
  output logic [NCH-1:0]  lock,
  output logic [NCH-1:0]  pdn_state,
  output logic [NCH-1:0]  ctr_rst,
  output logic            osc_buf_en,
  output logic            mux_out
);
  logic           rst_i;
  logic [NCH-1:0] up_q, dn_q, hold, mux_rst;

  pfd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pfd_core #(.RST_DLY(RST_DLY)) u_core (
      .clk(clk), .rst_n(rst_i), .hold(hold[c]),
      .ref_edge(ref_edge[c]), .fb_edge(fb_edge[c]),
      .up_q(up_q[c]), .dn_q(dn_q[c])
    );
    pfd_chan_ctrl u_ctl (
      .clk(clk), .rst_n(rst_i), .pwdn(cfg_pwdn[c]), .cfg_hiz(cfg_hiz[c]),
      .cfg_4x(cfg_4x[c]), .pol(cfg_pol[c]), .mux_rst(mux_rst[c]),
      .up_q(up_q[c]), .dn_q(dn_q[c]), .hold(hold[c]), .pd_q(pdn_state[c]),
      .mag_q(pump_4x[c]), .up_o(pump_up[c]), .dn_o(pump_dn[c]),
      .oe(pump_oe[c]), .lock(lock[c])
    );
  end

  assign ctr_rst    = hold;
  assign osc_buf_en = ~(&pdn_state);

  pfd_out_mux u_mux (
    .sel(mux_sel), .lock(lock), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .fast_mag(pump_4x[0]), .mux_out(mux_out), .mux_rst(mux_rst)
  );
endmodule

// File: rtl/pfd_lock_ctrl_chk.sv
module pfd_lock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_hiz,
  input logic [1:0] cfg_pwdn,
  input logic [3:0] mux_sel,
  input logic [1:0] pump_up,
  input logic [1:0] pump_dn,
  input logic [1:0] pump_oe,
  input logic [1:0] pump_4x,
  input logic [1:0] lock,
  input logic [1:0] pdn_state,
  input logic [1:0] ctr_rst,
  input logic       osc_buf_en
);
  logic [1:0] age_q;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign live = (age_q == 2'd3);

  p_pd_quiet_r6: assert property (@(posedge clk) disable iff (!live)
    (((pump_up | pump_dn | pump_oe | ~ctr_rst) & pdn_state) == 2'b00));

  p_lock_pd_r7: assert property (@(posedge clk) disable iff (!live)
    ((~lock & pdn_state) == 2'b00));

  p_async_a_r4: assert property (@(posedge clk) disable iff (!live)
    (cfg_pwdn[0] && cfg_hiz[0]) |=> pdn_state[0]);

  p_async_b_r4: assert property (@(posedge clk) disable iff (!live)
    (cfg_pwdn[1] && cfg_hiz[1]) |=> pdn_state[1]);

  p_sync_wait_r5: assert property (@(posedge clk) disable iff (!live)
    (cfg_pwdn[0] && !cfg_hiz[0] && !lock[0]) |=> !pdn_state[0]);

  p_mag_hold_r3: assert property (@(posedge clk) disable iff (!live)
    (pump_4x[0] != $past(pump_4x[0])) |-> $past(lock[0]));

  p_mux_rst_r11: assert property (@(posedge clk) disable iff (!live)
    (mux_sel == 4'b1111) |-> (ctr_rst == 2'b11 && pump_oe == 2'b00));

  p_osc_r12: assert property (@(posedge clk) disable iff (!live)
    (pdn_state != 2'b11) |-> osc_buf_en);
endmodule

bind pfd_lock_ctrl pfd_lock_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hiz(cfg_hiz), .cfg_pwdn(cfg_pwdn),
  .mux_sel(mux_sel), .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe),
  .pump_4x(pump_4x), .lock(lock), .pdn_state(pdn_state), .ctr_rst(ctr_rst),
  .osc_buf_en(osc_buf_en)
);

// File: tb/tb_pfd_lock_ctrl.sv
module tb_pfd_lock_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] ref_edge, fb_edge, cfg_pol, cfg_hiz, cfg_4x, cfg_pwdn;
  logic [3:0] mux_sel;
  logic [1:0] pump_up, pump_dn, pump_oe, pump_4x, lock, pdn_state, ctr_rst;
  logic osc_buf_en, mux_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfd_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .cfg_pol(cfg_pol), .cfg_hiz(cfg_hiz), .cfg_4x(cfg_4x), .cfg_pwdn(cfg_pwdn),
    .mux_sel(mux_sel), .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe),
    .pump_4x(pump_4x), .lock(lock), .pdn_state(pdn_state), .ctr_rst(ctr_rst),
    .osc_buf_en(osc_buf_en), .mux_out(mux_out)
  );

  // behavioural reference: per-channel request flags, pulse age, power and magnitude state
  int m_up[2]  = '{0, 0};
  int m_dn[2]  = '{0, 0};
  int m_age[2] = '{0, 0};
  int m_pd[2]  = '{0, 0};
  int m_mag[2] = '{0, 0};
  int rs1 = 0, rs2 = 0;

  function automatic int forced_off(int ch);
    if (mux_sel == 4'b1111) return 1;
    if (ch == 1 && mux_sel == 4'b0111) return 1;
    if (ch == 0 && mux_sel == 4'b1011) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    int live;
    live = rs2;
    for (int ch = 0; ch < 2; ch++) begin
      if (live == 0) begin
        m_up[ch] = 0; m_dn[ch] = 0; m_age[ch] = 0; m_pd[ch] = 0; m_mag[ch] = 0;
      end else begin
        int busy, off, fin, nu, nd, na, npd, nmag;
        busy = (m_up[ch] != 0 || m_dn[ch] != 0);
        off  = (m_pd[ch] != 0 || forced_off(ch) != 0);
        fin  = (m_up[ch] != 0 && m_dn[ch] != 0 && m_age[ch] == 0);
        npd  = (cfg_pwdn[ch] && (m_pd[ch] != 0 || cfg_hiz[ch] || !busy)) ? 1 : 0;
        nmag = busy ? m_mag[ch] : int'(cfg_4x[ch]);
        if (off) begin
          nu = 0; nd = 0; na = 0;
        end else begin
          nu = ((m_up[ch] != 0 && !fin) || ref_edge[ch]) ? 1 : 0;
          nd = ((m_dn[ch] != 0 && !fin) || fb_edge[ch]) ? 1 : 0;
          na = (m_up[ch] != 0 && m_dn[ch] != 0 && !fin) ? m_age[ch] + 1 : 0;
        end
        m_up[ch] = nu; m_dn[ch] = nd; m_age[ch] = na; m_pd[ch] = npd; m_mag[ch] = nmag;
      end
    end
    if (!rst_n) begin rs1 = 0; rs2 = 0; end
    else begin rs2 = rs1; rs1 = 1; end
  end

  task automatic cmp(string tag, string what, int ch, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s ch%0d at %0t: actual %b expected %b", tag, what, ch, $time, act, exp);
    end
  endtask

  task automatic check_all();
    logic exp_mux;
    for (int ch = 0; ch < 2; ch++) begin
      logic e_oe, e_u, e_d;
      e_oe = (m_pd[ch] == 0 && forced_off(ch) == 0);
      e_u  = e_oe && (cfg_pol[ch] ? (m_up[ch] != 0) : (m_dn[ch] != 0));
      e_d  = e_oe && (cfg_pol[ch] ? (m_dn[ch] != 0) : (m_up[ch] != 0));
      cmp("R1/R2", "pump_up", ch, pump_up[ch], e_u);
      cmp("R1/R2", "pump_dn", ch, pump_dn[ch], e_d);
      cmp("R6/R11", "pump_oe", ch, pump_oe[ch], e_oe);
      cmp("R6/R11", "ctr_rst", ch, ctr_rst[ch], !e_oe);
      cmp("R3", "pump_4x", ch, pump_4x[ch], m_mag[ch] != 0);
      cmp("R4/R5", "pdn_state", ch, pdn_state[ch], m_pd[ch] != 0);
      cmp("R7", "lock", ch, lock[ch], m_pd[ch] != 0 || (m_up[ch] == 0 && m_dn[ch] == 0));
    end
    cmp("R12", "osc_buf_en", 0, osc_buf_en, !(m_pd[0] != 0 && m_pd[1] != 0));
    if (mux_sel[1:0] == 2'b00) begin
      logic l0, l1;
      l0 = m_pd[0] != 0 || (m_up[0] == 0 && m_dn[0] == 0);
      l1 = m_pd[1] != 0 || (m_up[1] == 0 && m_dn[1] == 0);
      case (mux_sel[3:2])
        2'b00:   exp_mux = 1'b0;
        2'b01:   exp_mux = l1;
        2'b10:   exp_mux = l0;
        default: exp_mux = l0 && l1;
      endcase
      cmp("R8", "mux_out", 0, mux_out, exp_mux);
    end else if (mux_sel[1:0] == 2'b11) begin
      exp_mux = (mux_sel[3:2] == 2'b00) ? (m_mag[0] != 0) : 1'b0;
      cmp("R10/R11", "mux_out", 0, mux_out, exp_mux);
    end else begin
      int ch;
      ch = (mux_sel[1:0] == 2'b01) ? 1 : 0;
      exp_mux = mux_sel[2] ? fb_edge[ch] : ref_edge[ch];
      cmp("R9", "mux_out", ch, mux_out, exp_mux);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic strobe(logic [1:0] r, logic [1:0] f);
    ref_edge = r; fb_edge = f;
    tick();
    ref_edge = 2'b00; fb_edge = 2'b00;
  endtask

  initial begin
    rst_n = 1'b0;
    ref_edge = 0; fb_edge = 0; cfg_pol = 2'b11; cfg_hiz = 0; cfg_4x = 0;
    cfg_pwdn = 0; mux_sel = 4'b0000;
    tick(3);                           // reset state, all requirements idle
    rst_n = 1'b1;
    tick(4);
    // R1 R2: reference leads, then feedback leads, then coincident
    strobe(2'b01, 2'b00); tick(3); strobe(2'b00, 2'b01); tick(3);
    strobe(2'b00, 2'b10); tick(2); strobe(2'b10, 2'b00); tick(3);
    strobe(2'b11, 2'b11); tick(3);
    // R2: polarity swapped
    cfg_pol = 2'b00;
    strobe(2'b11, 2'b00); tick(2); strobe(2'b00, 2'b11); tick(3);
    cfg_pol = 2'b11;
    // R3: magnitude change requested mid-pulse, applied after
    strobe(2'b01, 2'b00); cfg_4x = 2'b01; tick(3); strobe(2'b00, 2'b01); tick(3);
    cfg_4x = 2'b00; tick(2);
    // R5: gated power-down on channel 0 while pulse in flight
    strobe(2'b01, 2'b00); cfg_pwdn = 2'b01; tick(4);
    strobe(2'b00, 2'b01); tick(3);
    strobe(2'b01, 2'b01); tick(2);    // R6: strobes ignored while down
    cfg_pwdn = 2'b00; tick(3);
    // R4: immediate power-down on channel 1 during pulse
    cfg_hiz = 2'b10;
    strobe(2'b10, 2'b00); cfg_pwdn = 2'b10; tick(3);
    // R12: both down
    cfg_hiz = 2'b11; cfg_pwdn = 2'b11; tick(3);
    cfg_pwdn = 2'b01; tick(2);
    cfg_pwdn = 2'b00; cfg_hiz = 2'b00; tick(3);
    // R8 R9 R10 R11: sweep every multiplexer code
    for (int code = 0; code < 16; code++) begin
      mux_sel = 4'(code);
      cfg_4x = 2'(code & 1);
      tick(2);
      strobe(2'b01, 2'b00); tick(1); strobe(2'b10, 2'b10);
      tick(1); strobe(2'b00, 2'b01); tick(1);
      strobe(2'b11, 2'b11); tick(3);
      cfg_4x = 2'b11; tick(2);
    end
    // R10: fast-lock switch follows applied magnitude of channel 0
    mux_sel = 4'b0011; cfg_4x = 2'b00; tick(2); cfg_4x = 2'b01; tick(2);
    mux_sel = 4'b0000; tick(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule